// File: doc/BRIEF.md
# Reliable-Link Control Frame Parser

This block sits on the receive path of a reliable FPGA-to-computer data link. Frames sent by the computer arrive one byte per cycle, with start-of-frame and end-of-frame markers. The block checks each frame's header against the local station address and the fixed link protocol identifiers. It then sorts the frame into one of two kinds and extracts that kind's fields.

An acknowledgement reports which stream packet arrived, its repetition number and the measured transmission delay. A command carries a code, a sequence number and an argument. Both kinds go into one small queue that the transmit side drains, and each entry carries a flag that tells the two apart. Frames that are misaddressed, that belong to another protocol or version, or that end too early leave the queue unchanged. A saturating-free counter records the entries lost because the queue was full.

Top module: `rlink_ctrl_parser`

## Requirements
- R1: A frame whose first six bytes (destination, most significant byte first) differ from `local_mac` pushes nothing.
- R2: Frame bytes 12..13 must be 0xFA,0xDE and bytes 14..15 must be 0x01,0x00. Any mismatch means nothing is pushed.
- R3: When the code in bytes 16..17 is 0x0003, an entry is pushed with layout: bit 96 = 1; [95:80] = code; [79:64] = repetition number (bytes 18..19); [63:32] = packet number (bytes 20..23); [31:0] = delay (bytes 24..27). All fields are big-endian.
- R4: Any other code pushes an entry with bit 96 = 0; [95:80] = code; [79:64] = sequence (bytes 18..19); [63:32] = argument (bytes 20..23); [31:0] = 0.
- R5: An acknowledgement shorter than 28 bytes, or a command shorter than 24 bytes, pushes nothing. Frames of exactly 28 and exactly 24 bytes are accepted.
- R6: Bytes beyond the decoded fields, such as padding up to 78 bytes, do not affect the entry.
- R7: A valid frame that arrives while the queue holds `DEPTH` entries is dropped, and `ovf_count` increases by one.
- R8: Entries leave the queue in arrival order. `q_valid` is high while the queue is non-empty, and asserting `q_pop` with `q_valid` high removes the head entry.
- R9: After reset the queue is empty and `ovf_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Station address that frames must target |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| q_pop | input | 1 | Remove head entry |
| q_valid | output | 1 | Queue non-empty |
| q_entry | output | 97 | Head entry |
| ovf_count | output | CW | Entries dropped on a full queue |

## Verification
The assertions assume that every frame starts with a byte that has `in_sof` set and ends with exactly one byte that has `in_eof` set. They also assume that `q_pop` is asserted only while `q_valid` is high. The bench sends whole frames, separated by idle cycles. Its monitor raises `q_pop` only in a cycle where it has just seen `q_valid` high, so the stimulus keeps to both assumptions.

// File: rtl/rlink_ctrl_parser.sv
module rlink_ctrl_parser #(
  parameter int DEPTH = 4,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = 97
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [47:0]   local_mac,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic          q_pop,
  output logic          q_valid,
  output logic [EW-1:0] q_entry,
  output logic [CW-1:0] ovf_count
);
  logic [6:0]  cnt, idx;
  logic        in_frame, bad, fin, hdr_ok;
  logic [15:0] code, f16;
  logic [31:0] f32, dly;
  logic [EW-1:0] mem [DEPTH];
  logic [AW:0] wp, rp;

  wire take   = in_valid && (in_sof || in_frame);
  wire is_ack = code == 16'h0003;
  wire push   = fin && !bad && (is_ack ? cnt >= 7'd28 : cnt >= 7'd24);
  wire [AW:0] level = wp - rp;
  wire full   = level == AW'(0) + (AW+1)'(DEPTH);

  assign idx = in_sof ? 7'd0 : cnt;

  always_comb begin
    case (idx)
      7'd0:    hdr_ok = in_data == local_mac[47:40];
      7'd1:    hdr_ok = in_data == local_mac[39:32];
      7'd2:    hdr_ok = in_data == local_mac[31:24];
      7'd3:    hdr_ok = in_data == local_mac[23:16];
      7'd4:    hdr_ok = in_data == local_mac[15:8];
      7'd5:    hdr_ok = in_data == local_mac[7:0];
      7'd12:   hdr_ok = in_data == 8'hFA;
      7'd13:   hdr_ok = in_data == 8'hDE;
      7'd14:   hdr_ok = in_data == 8'h01;
      7'd15:   hdr_ok = in_data == 8'h00;
      default: hdr_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; in_frame <= 1'b0; bad <= 1'b0; fin <= 1'b0;
      code <= '0; f16 <= '0; f32 <= '0; dly <= '0;
    end else begin
      fin <= take && in_eof;
      if (take) begin
        cnt      <= (idx == 7'd127) ? idx : idx + 7'd1;
        bad      <= (in_sof ? 1'b0 : bad) | !hdr_ok;
        in_frame <= !in_eof;
        if (idx == 7'd16 || idx == 7'd17) code <= {code[7:0], in_data};
        if (idx == 7'd18 || idx == 7'd19) f16  <= {f16[7:0], in_data};
        if (idx >= 7'd20 && idx <= 7'd23) f32  <= {f32[23:0], in_data};
        if (idx >= 7'd24 && idx <= 7'd27) dly  <= {dly[23:0], in_data};
      end
    end
  end

  assign q_valid = wp != rp;
  assign q_entry = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; ovf_count <= '0;
    end else begin
      if (push && !full) begin
        mem[wp[AW-1:0]] <= {is_ack, code, f16, f32, is_ack ? dly : 32'd0};
        wp <= wp + 1'b1;
      end
      if (push && full) ovf_count <= ovf_count + 1'b1;
      if (q_pop && q_valid) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/rlink_ctrl_parser_chk.sv
module rlink_ctrl_parser_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_eof,
  input logic          push,
  input logic          full,
  input logic [AW:0]   level,
  input logic          q_valid,
  input logic [CW-1:0] ovf_count
);
  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_count) |-> ovf_count == $past(ovf_count) + 1'b1);
  assert_ovf_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_count) |-> $past(full) && $past(push));
  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  assert_push_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> q_valid);
  assert_push_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(in_valid && in_eof));
endmodule

bind rlink_ctrl_parser rlink_ctrl_parser_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .push(push), .full(full), .level(level), .q_valid(q_valid),
  .ovf_count(ovf_count));

// File: tb/rlink_ctrl_parser_tb.sv
module rlink_ctrl_parser_tb_top;
  localparam int DEPTH = 4;
  localparam int CW = 8;
  localparam logic [47:0] MAC = 48'h02_1A_2B_3C_4D_5E;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, q_pop = 0;
  logic [7:0] in_data = 0;
  logic q_valid;
  logic [96:0] q_entry;
  logic [CW-1:0] ovf_count;
  int errors = 0, checks = 0;
  bit mon_en = 1;
  logic [96:0] exp_q[$];

  always #10 clk = ~clk;

  rlink_ctrl_parser #(.DEPTH(DEPTH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .local_mac(MAC), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .q_pop(q_pop),
    .q_valid(q_valid), .q_entry(q_entry), .ovf_count(ovf_count));

  task automatic check(input bit ok, input string tag,
                       input logic [96:0] act, input logic [96:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] dst, input logic [15:0] typ,
                      input logic [15:0] ver, input logic [15:0] code,
                      input logic [15:0] f16, input logic [31:0] f32,
                      input logic [31:0] dly, input int len, input bit expect_push);
    logic [7:0] b [0:79];
    for (int i = 0; i < 80; i++) b[i] = 8'hA5 ^ 8'(i);
    for (int i = 0; i < 6; i++) b[i] = dst[8*(5-i) +: 8];
    b[12] = typ[15:8]; b[13] = typ[7:0]; b[14] = ver[15:8]; b[15] = ver[7:0];
    b[16] = code[15:8]; b[17] = code[7:0]; b[18] = f16[15:8]; b[19] = f16[7:0];
    for (int i = 0; i < 4; i++) begin
      b[20+i] = f32[8*(3-i) +: 8];
      b[24+i] = dly[8*(3-i) +: 8];
    end
    if (expect_push)
      exp_q.push_back({code == 16'h0003, code, f16, f32,
                       code == 16'h0003 ? dly : 32'd0});
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = b[i];
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, 97'(exp_q.size()), 97'd0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      q_pop = 0;
      if (mon_en && q_valid) begin
        if (exp_q.size() == 0)
          check(0, "R1 R2 R5 unexpected entry", q_entry, 97'd0);
        else begin
          logic [96:0] e;
          e = exp_q.pop_front();
          check(q_entry === e, "R3 R4 R6 R8 entry", q_entry, e);
        end
        q_pop = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!q_valid, "R9 empty after reset", 97'(q_valid), 97'd0);
    check(ovf_count == 0, "R9 counter after reset", 97'(ovf_count), 97'd0);

    send(MAC, 16'hFADE, 16'h0100, 16'h0003, 16'h0002, 32'h0000_1234, 32'h0000_0BB8, 78, 1);
    send(MAC, 16'hFADE, 16'h0100, 16'h0007, 16'h8001, 32'hDEAD_BEEF, 32'h0, 78, 1);
    send(MAC, 16'hFADE, 16'h0100, 16'h0003, 16'hFFFF, 32'hFFFF_FFFE, 32'h1234_5678, 28, 1);
    send(MAC, 16'hFADE, 16'h0100, 16'h0001, 16'h0010, 32'h0102_0304, 32'h0, 24, 1);
    send(MAC, 16'hFADE, 16'h0100, 16'h0004, 16'h0011, 32'hCAFE_0000, 32'h0, 40, 1);
    drain("R3 R4 R6 accepted frames");

    send(MAC ^ 48'h1, 16'hFADE, 16'h0100, 16'h0003, 16'h1, 32'h1, 32'h1, 78, 0);
    drain("R1 wrong destination");
    send(MAC, 16'hFADF, 16'h0100, 16'h0003, 16'h1, 32'h1, 32'h1, 78, 0);
    drain("R2 wrong type");
    send(MAC, 16'hFADE, 16'h0101, 16'h0005, 16'h1, 32'h1, 32'h1, 78, 0);
    drain("R2 wrong version");
    send(MAC, 16'hFADE, 16'h0100, 16'h0003, 16'h1, 32'h1, 32'h1, 27, 0);
    drain("R5 short acknowledgement");
    send(MAC, 16'hFADE, 16'h0100, 16'h0009, 16'h1, 32'h1, 32'h1, 23, 0);
    drain("R5 short command");

    mon_en = 0;
    for (int k = 0; k < DEPTH + 2; k++)
      send(MAC, 16'hFADE, 16'h0100, 16'h0020, 16'(k), 32'(k * 7), 32'h0, 78, k < DEPTH);
    check(ovf_count == 8'd2, "R7 overflow count", 97'(ovf_count), 97'd2);
    check(q_valid, "R7 queue holds entries", 97'(q_valid), 97'd1);
    mon_en = 1;
    drain("R8 order after overflow");
    check(!q_valid, "R8 empty after draining", 97'(q_valid), 97'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule